// File: doc/BRIEF.md
# Power-Gate Control and Status Register Bank

This block is a 32-bit memory-mapped register bank that a power-sequencing controller uses to switch power domains. Software writes a control word per processor cluster (four gate bits and an isolation bit) and per memory group (one gate bit per bank). The gate bits drive individual output wires, and they can be read back through a read-only status word that mirrors them. The status word is not a stored copy.

A writable 32-bit local power-state word is also exported bit by bit on output wires. Four power-down status wires carry the inverse of its low four bits. Two groups of scratch words are included. The "keep" words are cleared only by a cold reset, so they carry data across warm resets. The "clear" words are zeroed by every reset.

A reset counts as cold when a power-on input has been seen since the last reset, or when no reset has happened yet. Only aligned 32-bit accesses are served. Write data is taken on the strobe edge, and read data appears on the following cycle.

Top module: `pwr_gate_regbank`

## Requirements
- R1: The cluster control word for cluster c sits at byte offset 8*c, with gate bits in [3:0] and the isolation bit in [4]. It resets to 0x0000000F. Bits 31:5 read as zero and ignore writes.
- R2: The bank control word for group g sits at offset 0x20+8*g, with one gate bit per bank at bit 8*k for bank k. It resets to 0x01010101, and every other bit reads as zero.
- R3: The status word sits 4 bytes above its control word. It returns exactly the gate bits of that control word, in the same positions, and writes to it have no effect.
- R4: Gate output wires change on the same clock edge that accepts a control write. Cluster c bit k appears on cl_gate_o[4*c+k], and group g bank k appears on bank_gate_o[4*g+k]. Outputs hold while no write occurs.
- R5: The local power-state word at offset 0x40 resets to 0x00FFFD87, and all 32 bits are writable. state_o always shows its value.
- R6: pdn_stat_o[k] is the inverse of power-state bit k, for k = 0 to 3.
- R7: The keep words at 0x60 to 0x6C are cleared only by a cold reset, meaning a reset with por_i high or a reset after por_i has pulsed since the last reset. A warm reset leaves them unchanged.
- R8: The clear words at 0x70 to 0x7C are zeroed by every reset, warm or cold.
- R9: rdata shows the read result on the cycle after rd_en and is zero on any cycle that follows a cycle without rd_en. Offsets 0x80 and above read as zero.
- R10: An access with addr[1:0] not equal to zero is ignored by writes and returns zero on reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on indication that marks the next reset as cold |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cl_gate_o | output | NUM_CL*GATE_W | Cluster gate wires |
| bank_gate_o | output | NUM_BANKREG*BANKS | Memory bank gate wires |
| state_o | output | 32 | Local power-state word, bit per wire |
| pdn_stat_o | output | 4 | Inverted power-state bits 3:0 |

## Verification
Control writes take effect at the strobe edge, so the gate wires, state_o and pdn_stat_o are checked at the falling edge right after the write cycle. A read result lands one edge after rd_en, so the bench samples rdata at the falling edge that ends the read cycle. It then confirms the zero on the next idle cycle. The reset cases are read back only after reset has been released, which separates what a warm reset keeps from what a cold reset clears.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  localparam int DATA_W      = 32;
  // word indices of each region (byte offset / 4)
  localparam int CL_BASE_W   = 0;
  localparam int BANK_BASE_W = 8;
  localparam int STATE_IDX_W = 16;
  localparam int KEEP_BASE_W = 24;
  localparam int CLR_BASE_W  = 28;
  localparam int MAP_END_W   = 32;
  localparam int BANK_STRIDE = 8;
  localparam logic [DATA_W-1:0] STATE_RST = 32'h00FF_FD87;
endpackage

// File: rtl/pgr_cluster_reg.sv
module pgr_cluster_reg #(
  parameter int GATE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [GATE_W:0]   wbits,
  output logic [GATE_W-1:0] gate,
  output logic              iso
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= '1;
      iso  <= 1'b0;
    end else if (we) begin
      gate <= wbits[GATE_W-1:0];
      iso  <= wbits[GATE_W];
    end
  end
endmodule

// File: rtl/pgr_bank_reg.sv
module pgr_bank_reg #(
  parameter int BANKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BANKS-1:0] wbits,
  output logic [BANKS-1:0] gate
);
  always_ff @(posedge clk) begin
    if (rst)     gate <= '1;
    else if (we) gate <= wbits;
  end
endmodule

// File: rtl/pgr_scratch.sv
module pgr_scratch #(
  parameter int WORDS  = 4,
  parameter int DW     = 32,
  parameter int IW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/pwr_gate_regbank.sv
module pwr_gate_regbank
  import pgr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_CL      = 3,
  parameter int GATE_W      = 4,
  parameter int NUM_BANKREG = 2,
  parameter int BANKS       = 4,
  parameter int NUM_KEEP    = 4,
  parameter int NUM_CLR     = 4,
  parameter int PDN_W       = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          por_i,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_CL*GATE_W-1:0]      cl_gate_o,
  output logic [NUM_BANKREG*BANKS-1:0]  bank_gate_o,
  output logic [DATA_W-1:0]             state_o,
  output logic [PDN_W-1:0]              pdn_stat_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int KIW    = (NUM_KEEP > 1) ? $clog2(NUM_KEEP) : 1;
  localparam int CIW    = (NUM_CLR > 1) ? $clog2(NUM_CLR) : 1;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_ok;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr_ok   = wr_en && aligned;

  // cold/warm reset tracking
  logic powered_q;
  logic cold_clr;

  always_ff @(posedge clk) begin
    if (rst)        powered_q <= 1'b1;
    else if (por_i) powered_q <= 1'b0;
  end

  assign cold_clr = rst && (por_i || !powered_q);

  // cluster control words
  logic [NUM_CL-1:0][GATE_W-1:0] cl_gate;
  logic [NUM_CL-1:0]             cl_iso;

  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    pgr_cluster_reg #(.GATE_W(GATE_W)) u_cl (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_ok && (word == WORD_W'(CL_BASE_W + 2*c))),
      .wbits (wdata[GATE_W:0]),
      .gate  (cl_gate[c]),
      .iso   (cl_iso[c])
    );
    assign cl_gate_o[c*GATE_W +: GATE_W] = cl_gate[c];
  end

  // bank-style control words, one gate bit every BANK_STRIDE bits
  logic [NUM_BANKREG-1:0][BANKS-1:0] bank_gate;
  logic [BANKS-1:0]                  bank_wbits;

  for (genvar k = 0; k < BANKS; k++) begin : g_spread
    assign bank_wbits[k] = wdata[k*BANK_STRIDE];
  end

  for (genvar b = 0; b < NUM_BANKREG; b++) begin : g_bank
    pgr_bank_reg #(.BANKS(BANKS)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_ok && (word == WORD_W'(BANK_BASE_W + 2*b))),
      .wbits (bank_wbits),
      .gate  (bank_gate[b])
    );
    assign bank_gate_o[b*BANKS +: BANKS] = bank_gate[b];
  end

  // local power-state word
  logic [DATA_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= STATE_RST;
    else if (wr_ok && (word == WORD_W'(STATE_IDX_W))) state_q <= wdata;
  end

  assign state_o    = state_q;
  assign pdn_stat_o = ~state_q[PDN_W-1:0];

  // scratch storage
  logic              in_keep, in_clr;
  logic [KIW-1:0]    keep_idx;
  logic [CIW-1:0]    clr_idx;
  logic [DATA_W-1:0] keep_rd, clr_rd;

  assign in_keep  = (word >= WORD_W'(KEEP_BASE_W)) && (word < WORD_W'(KEEP_BASE_W + NUM_KEEP));
  assign in_clr   = (word >= WORD_W'(CLR_BASE_W)) && (word < WORD_W'(CLR_BASE_W + NUM_CLR));
  assign keep_idx = KIW'(word - WORD_W'(KEEP_BASE_W));
  assign clr_idx  = CIW'(word - WORD_W'(CLR_BASE_W));

  pgr_scratch #(.WORDS(NUM_KEEP), .DW(DATA_W), .IW(KIW)) u_keep (
    .clk   (clk),
    .clr   (cold_clr),
    .we    (wr_ok && in_keep),
    .idx   (keep_idx),
    .wdata (wdata),
    .rdata (keep_rd)
  );

  pgr_scratch #(.WORDS(NUM_CLR), .DW(DATA_W), .IW(CIW)) u_clr (
    .clk   (clk),
    .clr   (rst),
    .we    (wr_ok && in_clr),
    .idx   (clr_idx),
    .wdata (wdata),
    .rdata (clr_rd)
  );

  // read mux
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CL; c++) begin
      if (word == WORD_W'(CL_BASE_W + 2*c))     rd_word[GATE_W:0]   = {cl_iso[c], cl_gate[c]};
      if (word == WORD_W'(CL_BASE_W + 2*c + 1)) rd_word[GATE_W-1:0] = cl_gate[c];
    end
    for (int b = 0; b < NUM_BANKREG; b++) begin
      if ((word == WORD_W'(BANK_BASE_W + 2*b)) || (word == WORD_W'(BANK_BASE_W + 2*b + 1))) begin
        for (int k = 0; k < BANKS; k++) rd_word[k*BANK_STRIDE] = bank_gate[b][k];
      end
    end
    if (word == WORD_W'(STATE_IDX_W)) rd_word = state_q;
    if (in_keep) rd_word = keep_rd;
    if (in_clr)  rd_word = clr_rd;
    if (!aligned) rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
    else            rdata <= '0;
  end
endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
  parameter int ADDR_W = 8,
  parameter int GATE_W = 4,
  parameter int CL_BITS = 12,
  parameter int BK_BITS = 8,
  parameter int PDN_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        rdata,
  input logic [CL_BITS-1:0] cl_gate_o,
  input logic [BK_BITS-1:0] bank_gate_o,
  input logic [PDN_W-1:0]   pdn_stat_o
);
  localparam logic [ADDR_W-1:0] A_CL0   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CL0S  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_BK0   = ADDR_W'(32);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(64);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(112);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(128);

  // R1
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_CL0 |=> rdata[31:GATE_W+1] == '0);
  // R2
  p_bank_rsv_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_BK0 |=> (rdata & 32'hFEFE_FEFE) == 32'h0);
  // R3
  p_status_pins_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_CL0S |=> rdata[GATE_W-1:0] == $past(cl_gate_o[GATE_W-1:0]));
  // R4
  p_gate_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cl_gate_o) && $stable(bank_gate_o));
  // R6
  p_pdn_inv_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_STATE |=> rdata[PDN_W-1:0] == ~$past(pdn_stat_o));
  // R8
  p_clr_after_rst_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && rd_en && addr == A_CLR0 |=> rdata == 32'h0);
  // R9
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == 32'h0);
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr >= A_END |=> rdata == 32'h0);
  // R10
  p_misalign_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr[1:0] != 2'b00 |=> rdata == 32'h0);
endmodule

bind pwr_gate_regbank pgr_checker #(
  .ADDR_W (ADDR_W),
  .GATE_W (GATE_W),
  .CL_BITS(NUM_CL*GATE_W),
  .BK_BITS(NUM_BANKREG*BANKS),
  .PDN_W  (PDN_W)
) u_chk (.*);

// File: tb/pwr_gate_regbank_test.sv
`timescale 1ns/1ps
module pwr_gate_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por_i = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] cl_gate_o;
  logic [7:0]  bank_gate_o;
  logic [31:0] state_o;
  logic [3:0]  pdn_stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_gate_regbank uut (
    .clk(clk), .rst(rst), .por_i(por_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cl_gate_o(cl_gate_o),
    .bank_gate_o(bank_gate_o), .state_o(state_o), .pdn_stat_o(pdn_stat_o)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'hFFFF_FFE5, 4'd1},  // R1 upper bits dropped
    '{1'b1, 8'h00, 32'h0000_0005, 4'd1},
    '{1'b1, 8'h04, 32'h0000_0005, 4'd3},  // R3 mirror
    '{1'b0, 8'h08, 32'h0000_001A, 4'd1},
    '{1'b1, 8'h08, 32'h0000_001A, 4'd1},
    '{1'b1, 8'h0C, 32'h0000_000A, 4'd3},
    '{1'b0, 8'h04, 32'h0000_0000, 4'd3},  // status write ignored
    '{1'b1, 8'h04, 32'h0000_0005, 4'd3},
    '{1'b0, 8'h20, 32'hFFFF_FFFF, 4'd2},  // R2
    '{1'b1, 8'h20, 32'h0101_0101, 4'd2},
    '{1'b0, 8'h20, 32'h0001_0100, 4'd2},
    '{1'b1, 8'h20, 32'h0001_0100, 4'd2},
    '{1'b1, 8'h24, 32'h0001_0100, 4'd3},
    '{1'b0, 8'h28, 32'h0100_0001, 4'd2},
    '{1'b1, 8'h2C, 32'h0100_0001, 4'd3},
    '{1'b0, 8'h40, 32'hA5A5_A5A0, 4'd5},  // R5
    '{1'b1, 8'h40, 32'hA5A5_A5A0, 4'd5},
    '{1'b0, 8'h60, 32'h1234_5678, 4'd7},  // R7
    '{1'b1, 8'h60, 32'h1234_5678, 4'd7},
    '{1'b0, 8'h70, 32'hCAFE_F00D, 4'd8},  // R8
    '{1'b1, 8'h70, 32'hCAFE_F00D, 4'd8},
    '{1'b1, 8'h90, 32'h0000_0000, 4'd9},  // R9 unmapped
    '{1'b0, 8'h01, 32'h0000_0000, 4'd10}, // R10 misaligned write
    '{1'b1, 8'h00, 32'h0000_0005, 4'd10},
    '{1'b1, 8'h41, 32'h0000_0000, 4'd10},
    '{1'b0, 8'h14, 32'h0000_0000, 4'd3},
    '{1'b1, 8'h10, 32'h0000_000F, 4'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_reset(input bit with_por);
    @(negedge clk);
    rst = 1'b1; por_i = with_por;
    @(negedge clk);
    rst = 1'b0; por_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0; por_i = 1'b0;
    @(negedge clk);
    // reset state
    check("R9 rdata reset", rdata, 32'h0);
    check("R4 cluster pins reset", {20'h0, cl_gate_o}, 32'h0000_0FFF);
    check("R4 bank pins reset", {24'h0, bank_gate_o}, 32'h0000_00FF);
    check("R5 state reset", state_o, 32'h00FF_FD87);
    check("R6 pdn reset", {28'h0, pdn_stat_o}, 32'h8);
    rd(8'h0C, v); check("R3 status reset", v, 32'h0000_000F);
    rd(8'h2C, v); check("R2 bank reset", v, 32'h0101_0101);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        rd(VECS[i].a, v);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].d);
      end else begin
        wr(VECS[i].a, VECS[i].d);
      end
    end

    // pins after table
    check("R4 cluster pins", {20'h0, cl_gate_o}, 32'h0000_0FA5);
    check("R4 bank pins", {24'h0, bank_gate_o}, 32'h0000_0096);
    check("R5 state pins", state_o, 32'hA5A5_A5A0);
    check("R6 pdn pins", {28'h0, pdn_stat_o}, 32'hF);
    wr(8'h10, 32'h3);
    check("R4 pins on write edge", {20'h0, cl_gate_o}, 32'h0000_03A5);
    wr(8'h40, 32'h0000_0009);
    check("R6 pdn follows", {28'h0, pdn_stat_o}, 32'h6);

    // R9 timing: result one cycle later, zero afterwards
    rd(8'h40, v); check("R9 read latency", v, 32'h0000_0009);
    @(negedge clk); check("R9 idle zero", rdata, 32'h0);

    // warm reset
    wr(8'h64, 32'hDEAD_0001);
    pulse_reset(1'b0);
    rd(8'h60, v); check("R7 warm keeps word0", v, 32'h1234_5678);
    rd(8'h64, v); check("R7 warm keeps word1", v, 32'hDEAD_0001);
    rd(8'h70, v); check("R8 warm clears", v, 32'h0);
    rd(8'h00, v); check("R1 warm reset ctrl", v, 32'h0000_000F);
    check("R4 pins after warm", {20'h0, cl_gate_o}, 32'h0000_0FFF);
    check("R5 state after warm", state_o, 32'h00FF_FD87);

    // cold reset: por pulse, then reset
    wr(8'h74, 32'h5555_AAAA);
    @(negedge clk); por_i = 1'b1;
    @(negedge clk); por_i = 1'b0;
    pulse_reset(1'b0);
    rd(8'h60, v); check("R7 cold clears word0", v, 32'h0);
    rd(8'h64, v); check("R7 cold clears word1", v, 32'h0);
    rd(8'h74, v); check("R8 cold clears", v, 32'h0);

    // cold reset with por and reset together
    wr(8'h68, 32'h0BAD_F00D);
    pulse_reset(1'b0);
    rd(8'h68, v); check("R7 second warm keeps", v, 32'h0BAD_F00D);
    pulse_reset(1'b1);
    rd(8'h68, v); check("R7 por with reset clears", v, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule